// File: doc/BRIEF.md
# Memory Transaction Trace Logger

The block sits beside a processor core and its main-memory port and keeps a rolling record of the traffic between them. Every core request (a read or write strobe with an address and a data block) goes into one log, together with its operation type. Every response returned by memory (a valid strobe with an address and a data block) goes into a second, separate log. Each log is a ring: after its last slot is filled, the next event overwrites slot 0. Each stream has its own event counter, and the counters keep running past the ring depth.

A host inspects the record through a snoop port. It presents a command code and an index, and one cycle later the block shows the result on a debug bus. The result is either a stored log entry or one of the event counts. The host can find the newest entry of a stream as (count - 1) mod depth.

Top module: `trace_logger`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), both event counters and both write slots return to zero and `dbg_vld_o` is low; count queries issued after reset return 0.
- R2: In every cycle with `mem_vld_i` high, the memory address and data are stored in the memory log and the memory count rises by one. In cycles with `mem_vld_i` low, the memory inputs change neither the log nor the count.
- R3: In every cycle with `core_wr_i` or `core_rd_i` high, exactly one core-log entry is stored, holding the address, the data and a write flag. The write flag is 1 if `core_wr_i` is high, so a write wins when both strobes are high. With both strobes low, nothing is stored.
- R4: The n-th event of a stream since reset (counting from 0) lands in slot n mod DEPTH and overwrites whatever that slot held.
- R5: Snoop code 0 reads the core log and code 1 reads the memory log, at slot `snp_idx_i` mod DEPTH (DEPTH is a power of two). The bus shows the stored address and data, with `dbg_id_o` echoing the full index. For a core entry, `dbg_is_wr_o` is the stored flag and `dbg_is_rd_o` is its inverse. For a memory entry, both flags are 0.
- R6: Code 2 returns the core count and code 3 returns the memory count. The count is zero-extended on `dbg_data_o`, and the address, id and both flags are 0. The counters wrap modulo 2^CNT_W and never saturate.
- R7: Code 4 returns (core count + memory count) mod 2^CNT_W, with the other fields handled as in R6.
- R8: A snoop is accepted in a cycle with `snp_vld_i` high. `dbg_vld_o` is high for exactly the following cycle, and every field is 0 whenever `dbg_vld_o` is low. The result reflects the logs and counts as they stood before any capture made in the accepting cycle.
- R9: Codes 5 to 7 still produce the one-cycle valid pulse, with all data fields 0.
- R10: Reset does not clear the stored log contents. Entries written before a reset can be read back after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_wr_i | input | 1 | Core write strobe |
| core_rd_i | input | 1 | Core read strobe |
| core_addr_i | input | ADDR_W | Core request address |
| core_data_i | input | DATA_W | Core request data block |
| mem_vld_i | input | 1 | Memory response valid |
| mem_addr_i | input | ADDR_W | Memory response address |
| mem_data_i | input | DATA_W | Memory response data block |
| snp_vld_i | input | 1 | Snoop command valid |
| snp_cmd_i | input | 3 | Snoop command code |
| snp_idx_i | input | ADDR_W | Log entry index for read commands |
| dbg_vld_o | output | 1 | Snoop result valid |
| dbg_addr_o | output | ADDR_W | Entry address |
| dbg_data_o | output | DATA_W | Entry data or count |
| dbg_id_o | output | ADDR_W | Echoed entry index |
| dbg_is_wr_o | output | 1 | Entry was a core write |
| dbg_is_rd_o | output | 1 | Entry was a core read |

## Verification
The bench builds the block with DEPTH=4, CNT_W=6, ADDR_W=8 and DATA_W=16. With a four-slot ring, each stream wraps after a handful of events, so every slot can be read back after an overwrite. Snoop indices larger than the depth then exercise the index aliasing. A 6-bit counter overflows after 64 events, so the bench can drive the counter wrap and the wrap of the total sum within a short run. These small widths also let it sweep every snoop code, including the unused ones.

// File: rtl/trace_logger_pkg.sv
package trace_logger_pkg;

  typedef enum logic [2:0] {
    SNP_CORE_ENTRY = 3'd0,
    SNP_MEM_ENTRY  = 3'd1,
    SNP_CORE_CNT   = 3'd2,
    SNP_MEM_CNT    = 3'd3,
    SNP_TOTAL_CNT  = 3'd4
  } snp_cmd_e;

endpackage

// File: rtl/tl_ring_log.sv
module tl_ring_log #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [IDX_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rd_q;

  // storage is not reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
    if (rd_en_i) rd_q <= mem_q[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (wr_en_i) begin
      wr_ptr_q <= (wr_ptr_q == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr_q + IDX_W'(1);
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign rd_data_o = rd_q;
  assign cnt_o     = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cnt_q) && $stable(wr_ptr_q)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ptr_q == IDX_W'(DEPTH - 1) |=> wr_ptr_q == '0); // R4
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_ptr_q) < DEPTH); // R4

endmodule

// File: rtl/tl_snoop_port.sv
module tl_snoop_port
  import trace_logger_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   snp_vld_i,
  input  snp_cmd_e               snp_cmd_i,
  input  logic [ADDR_W-1:0]      snp_idx_i,
  input  logic [CNT_W-1:0]       core_cnt_i,
  input  logic [CNT_W-1:0]       mem_cnt_i,
  input  logic [ADDR_W+DATA_W:0] core_ent_i,
  input  logic [ADDR_W+DATA_W-1:0] mem_ent_i,
  output logic                   dbg_vld_o,
  output logic [ADDR_W-1:0]      dbg_addr_o,
  output logic [DATA_W-1:0]      dbg_data_o,
  output logic [ADDR_W-1:0]      dbg_id_o,
  output logic                   dbg_is_wr_o,
  output logic                   dbg_is_rd_o
);

  logic             vld_q;
  snp_cmd_e         cmd_q;
  logic [ADDR_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q, cnt_sel;

  always_comb begin
    case (snp_cmd_i)
      SNP_CORE_CNT:  cnt_sel = core_cnt_i;
      SNP_MEM_CNT:   cnt_sel = mem_cnt_i;
      SNP_TOTAL_CNT: cnt_sel = core_cnt_i + mem_cnt_i;
      default:       cnt_sel = '0;
    endcase
  end

  // counts are sampled at accept time, before this cycle's capture lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cmd_q <= SNP_CORE_ENTRY;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= snp_vld_i;
      if (snp_vld_i) begin
        cmd_q <= snp_cmd_i;
        idx_q <= snp_idx_i;
        cnt_q <= cnt_sel;
      end
    end
  end

  always_comb begin
    dbg_addr_o  = '0;
    dbg_data_o  = '0;
    dbg_id_o    = '0;
    dbg_is_wr_o = 1'b0;
    dbg_is_rd_o = 1'b0;
    if (vld_q) begin
      case (cmd_q)
        SNP_CORE_ENTRY: begin
          dbg_addr_o  = core_ent_i[DATA_W +: ADDR_W];
          dbg_data_o  = core_ent_i[DATA_W-1:0];
          dbg_id_o    = idx_q;
          dbg_is_wr_o = core_ent_i[ADDR_W+DATA_W];
          dbg_is_rd_o = !core_ent_i[ADDR_W+DATA_W];
        end
        SNP_MEM_ENTRY: begin
          dbg_addr_o = mem_ent_i[DATA_W +: ADDR_W];
          dbg_data_o = mem_ent_i[DATA_W-1:0];
          dbg_id_o   = idx_q;
        end
        SNP_CORE_CNT, SNP_MEM_CNT, SNP_TOTAL_CNT: dbg_data_o = DATA_W'(cnt_q);
        default: ;
      endcase
    end
  end

  assign dbg_vld_o = vld_q;

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i |=> dbg_vld_o); // R8
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_vld_i |=> !dbg_vld_o); // R8
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_vld_o |-> dbg_data_o == '0 && dbg_addr_o == '0 && !dbg_is_wr_o && !dbg_is_rd_o); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dbg_is_wr_o && dbg_is_rd_o)); // R5
  AST_CNT_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i && (snp_cmd_i == SNP_CORE_CNT || snp_cmd_i == SNP_MEM_CNT)
    |=> dbg_addr_o == '0 && dbg_id_o == '0 && !dbg_is_wr_o && !dbg_is_rd_o); // R6
  AST_BAD_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i && snp_cmd_i > SNP_TOTAL_CNT |=> dbg_data_o == '0 && dbg_addr_o == '0); // R9

endmodule

// File: rtl/trace_logger.sv
module trace_logger
  import trace_logger_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_wr_i,
  input  logic              core_rd_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              mem_vld_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              snp_vld_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_idx_i,
  output logic              dbg_vld_o,
  output logic [ADDR_W-1:0] dbg_addr_o,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [ADDR_W-1:0] dbg_id_o,
  output logic              dbg_is_wr_o,
  output logic              dbg_is_rd_o
);

  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MEM_W  = ADDR_W + DATA_W;
  localparam int CORE_W = MEM_W + 1;

  snp_cmd_e          cmd;
  logic              core_en;
  logic [CORE_W-1:0] core_ent, core_rd_ent;
  logic [MEM_W-1:0]  mem_rd_ent;
  logic [CNT_W-1:0]  core_cnt, mem_cnt;
  logic [IDX_W-1:0]  rd_idx;

  assign cmd      = snp_cmd_e'(snp_cmd_i);
  assign core_en  = core_wr_i | core_rd_i;
  assign core_ent = {core_wr_i, core_addr_i, core_data_i}; // write wins
  assign rd_idx   = snp_idx_i[IDX_W-1:0];

  tl_ring_log #(.W(CORE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_core_log (
    .clk_i, .rst_ni,
    .wr_en_i   (core_en),
    .wr_data_i (core_ent),
    .rd_en_i   (snp_vld_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (core_rd_ent),
    .cnt_o     (core_cnt)
  );

  tl_ring_log #(.W(MEM_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_mem_log (
    .clk_i, .rst_ni,
    .wr_en_i   (mem_vld_i),
    .wr_data_i ({mem_addr_i, mem_data_i}),
    .rd_en_i   (snp_vld_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (mem_rd_ent),
    .cnt_o     (mem_cnt)
  );

  tl_snoop_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_vld_i, .snp_cmd_i(cmd), .snp_idx_i,
    .core_cnt_i (core_cnt),
    .mem_cnt_i  (mem_cnt),
    .core_ent_i (core_rd_ent),
    .mem_ent_i  (mem_rd_ent),
    .dbg_vld_o, .dbg_addr_o, .dbg_data_o, .dbg_id_o, .dbg_is_wr_o, .dbg_is_rd_o
  );

  AST_TOTAL_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i && snp_cmd_i == 3'd4
    |=> dbg_data_o == DATA_W'($past(CNT_W'(core_cnt + mem_cnt)))); // R7
  AST_CORE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i && core_rd_i |=> core_cnt == $past(core_cnt) + CNT_W'(1)); // R3

endmodule

// File: tb/sim_trace_logger.sv
`timescale 1ns/1ps
module sim_trace_logger;
  localparam int AW = 8, DW = 16, DP = 4, CW = 6;
  localparam int CMOD = 1 << CW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic core_wr_i = 0, core_rd_i = 0, mem_vld_i = 0, snp_vld_i = 0;
  logic [AW-1:0] core_addr_i = '0, mem_addr_i = '0, snp_idx_i = '0;
  logic [DW-1:0] core_data_i = '0, mem_data_i = '0;
  logic [2:0] snp_cmd_i = '0;
  logic dbg_vld_o, dbg_is_wr_o, dbg_is_rd_o;
  logic [AW-1:0] dbg_addr_o, dbg_id_o;
  logic [DW-1:0] dbg_data_o;

  always #2.5 clk_i = ~clk_i;

  trace_logger #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int m_addr[DP], m_data[DP], c_addr[DP], c_data[DP], c_wr[DP];
  int m_cnt = 0, c_cnt = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    core_wr_i = 0; core_rd_i = 0; mem_vld_i = 0; snp_vld_i = 0;
    @(negedge clk_i);
  endtask

  // sets inputs at a negedge and advances one cycle; consecutive calls are back to back
  task automatic mem_evt(int a, int d);
    mem_vld_i = 1; mem_addr_i = AW'(a); mem_data_i = DW'(d);
    @(negedge clk_i);
    m_addr[m_cnt % DP] = a & 8'hff; m_data[m_cnt % DP] = d & 16'hffff; m_cnt++;
  endtask

  task automatic core_evt(bit wr, bit rd, int a, int d);
    core_wr_i = wr; core_rd_i = rd; core_addr_i = AW'(a); core_data_i = DW'(d);
    @(negedge clk_i);
    if (wr || rd) begin
      c_addr[c_cnt % DP] = a & 8'hff; c_data[c_cnt % DP] = d & 16'hffff;
      c_wr[c_cnt % DP] = wr; c_cnt++;
    end
  endtask

  task automatic snoop(int cmd, int idx);
    snp_vld_i = 1; snp_cmd_i = 3'(cmd); snp_idx_i = AW'(idx);
    @(negedge clk_i);
    snp_vld_i = 0;
  endtask

  task automatic chk_entry(string req, bit core, int idx);
    int s;
    s = idx % DP;
    snoop(core ? 0 : 1, idx);
    chk({req, " vld"}, int'(dbg_vld_o), 1);
    chk({req, " addr"}, int'(dbg_addr_o), core ? c_addr[s] : m_addr[s]);
    chk({req, " data"}, int'(dbg_data_o), core ? c_data[s] : m_data[s]);
    chk({req, " id"}, int'(dbg_id_o), idx);
    chk({req, " wr"}, int'(dbg_is_wr_o), core ? c_wr[s] : 0);
    chk({req, " rd"}, int'(dbg_is_rd_o), core ? 1 - c_wr[s] : 0);
    @(negedge clk_i);
    chk({req, " pulse"}, int'(dbg_vld_o), 0);
  endtask

  task automatic chk_count(string req, int cmd, int exp);
    snoop(cmd, 8'h5a);
    chk({req, " cnt vld"}, int'(dbg_vld_o), 1);
    chk({req, " cnt"}, int'(dbg_data_o), exp % CMOD);
    chk({req, " cnt zero fields"}, int'(dbg_addr_o) + int'(dbg_id_o) + int'(dbg_is_wr_o) + int'(dbg_is_rd_o), 0);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 vld in reset", int'(dbg_vld_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk_count("R1 core", 2, 0);
    chk_count("R1 mem", 3, 0);
    chk_count("R1 total", 4, 0);

    // R2 R4: six back-to-back responses wrap a 4-slot ring
    for (int i = 0; i < 6; i++) mem_evt(8'h10 + i, 16'ha000 + 3 * i);
    idle();
    for (int i = 0; i < DP; i++) chk_entry("R2 R4 mem", 0, i);
    chk_count("R6 mem", 3, m_cnt);
    // R2: inputs move with valid low
    mem_addr_i = 8'hee; mem_data_i = 16'hdead;
    repeat (3) @(negedge clk_i);
    chk_count("R2 idle mem", 3, m_cnt);
    chk_entry("R2 idle slot", 0, 1);

    // R3: mixed reads, writes, both, none
    for (int i = 0; i < 7; i++) core_evt(i % 2 == 0, i % 3 == 0, 8'h40 + i, 16'h1234 * (i + 1));
    core_evt(0, 0, 8'hff, 16'hffff);
    idle();
    for (int i = 0; i < DP; i++) chk_entry("R3 R5 core", 1, i);
    chk_count("R3 core", 2, c_cnt);
    chk_count("R7 total", 4, c_cnt + m_cnt);

    // R5: index aliasing modulo depth, full index echoed
    chk_entry("R5 alias core", 1, 4 + 1);
    chk_entry("R5 alias mem", 0, 8 + 3);

    // R9: unused codes
    for (int c = 5; c < 8; c++) begin
      snoop(c, 2);
      chk("R9 vld", int'(dbg_vld_o), 1);
      chk("R9 zero", int'(dbg_data_o) + int'(dbg_addr_o) + int'(dbg_id_o) + int'(dbg_is_wr_o) + int'(dbg_is_rd_o), 0);
      @(negedge clk_i);
    end

    // R8: snoop and capture in the same cycle return the old state
    begin
      int s, oa, od, oc;
      s = m_cnt % DP; oa = m_addr[s]; od = m_data[s]; oc = m_cnt;
      snp_vld_i = 1; snp_cmd_i = 3'd1; snp_idx_i = AW'(s);
      mem_evt(8'h77, 16'h7777);
      snp_vld_i = 0; mem_vld_i = 0;
      chk("R8 old addr", int'(dbg_addr_o), oa);
      chk("R8 old data", int'(dbg_data_o), od);
      @(negedge clk_i);
      snp_vld_i = 1; snp_cmd_i = 3'd3;
      mem_evt(8'h78, 16'h7878);
      snp_vld_i = 0; mem_vld_i = 0;
      chk("R8 old count", int'(dbg_data_o), (oc + 1) % CMOD);
      @(negedge clk_i);
      chk_entry("R8 new entry", 0, s);
    end

    // R6 R7: drive counts past 2^CW
    while (m_cnt < CMOD + 5) mem_evt(m_cnt, m_cnt * 7);
    idle();
    chk_count("R6 wrap", 3, m_cnt);
    chk_count("R7 wrap", 4, c_cnt + m_cnt);
    for (int i = 0; i < DP; i++) chk_entry("R4 late mem", 0, i);

    // R10: reset keeps log contents
    rst_ni = 0;
    @(negedge clk_i);
    chk("R1 vld reset", int'(dbg_vld_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    m_cnt = 0; c_cnt = 0;
    chk_count("R1 core after", 2, 0);
    chk_count("R1 total after", 4, 0);
    for (int i = 0; i < DP; i++) chk_entry("R10 mem kept", 0, i);
    for (int i = 0; i < DP; i++) chk_entry("R10 core kept", 1, i);
    // R4: first event after reset lands in slot 0
    core_evt(1, 0, 8'h99, 16'h9999);
    idle();
    chk_entry("R4 slot0 after reset", 1, 0);

    summary();
  end
endmodule